// File: doc/BRIEF.md
# Multi-Read-Port Register File

This block is a small storage array for a datapath. It has one clocked write port and one, two or four read ports. Each read port is a plain combinational path from its address to its data, so a read address can change and be used in the same cycle. A write stores data on the rising clock edge. A mask limits the write to selected bits. A parameter sets the mask granularity: one mask bit per data bit, or one mask bit per byte.

A parameter can turn on a bypass. With the bypass on, a read port that addresses the word being written in the current cycle shows the new data for the enabled bits in that same cycle. The bits that are not enabled come from the stored word.

An active-low reset, sampled on the clock, clears every word. A retention input freezes the contents: while it is high, every write is dropped. Word count, word width, read-port count, mask granularity and bypass are all parameters. The word count may be smaller than the address range. Addresses above the last word read as zero, and writes to them are dropped.

Top module: `mrp_regfile`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every word becomes zero. After that edge, all read ports return zero for every in-range address.
- R2: When `wr_en` is high at a rising clock edge, and neither reset, retention nor an out-of-range address blocks it, the enabled bits of word `wr_addr` take `wr_data`. Reads show the new value from the following cycle.
- R3: Each read port `p` drives `rd_data[p*WIDTH +: WIDTH]` combinationally from `rd_addr[p*AW +: AW]`, with no clock. The ports are independent of each other.
- R4: Write masking. In bit mode (`BYTE_MODE`=0), `wr_mask[i]` enables data bit i. In byte mode (`BYTE_MODE`=1), `wr_mask[j]` enables data bits 8j to 8j+7. Bits that are not enabled keep their stored value.
- R5: With `WRITE_THRU`=1, a read port whose address equals `wr_addr` during an effective write shows `wr_data` on the enabled bits in that same cycle. Its other bits show the stored word. With `WRITE_THRU`=0, a read port shows only stored contents.
- R6: While `ret_hold` is high and `rst_n` is high, writes are dropped, the stored contents do not change and no bypass takes place.
- R7: Reset has priority over retention and write. A clock edge with `rst_n` low clears the array even when `ret_hold` and `wr_en` are high.
- R8: A read address of `WORDS` or more returns all zeros. A write to such an address changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and reset clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock; clears all words |
| ret_hold | input | 1 | Retention: drops all writes while high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | WIDTH | Write data |
| wr_mask | input | MASK_W | Per-bit or per-byte write enable |
| rd_addr | input | RD_PORTS*AW | Read addresses, port p in slice p*AW |
| rd_data | output | RD_PORTS*WIDTH | Read data, port p in slice p*WIDTH |

## Verification
Some properties are checked every cycle:
- The array keeps its contents across any edge where no write takes effect. This covers retention, disabled writes and out-of-range addresses.
- The array reads all zeros after a reset edge.
- Out-of-range reads return zero.
- With the bypass on, the enabled bits of an addressed read port equal the incoming write data.

Other behaviour can only be shown by the bench's scenarios: the exact merge of masked bits into a stored word, the byte grouping of the mask, reset winning over a simultaneous retention and write, and the absence of a bypass when it is configured off. The bench runs two configurations and compares them against a behavioural model on every clock.

// File: rtl/mrp_rf_pkg.sv
// Package: shared helpers for the multi-read-port register file.
// Assumes byte granularity means groups of 8 bits, the top group possibly partial.
package mrp_rf_pkg;

    // Number of mask bits for a given word width and granularity.
    function automatic int mask_width(input int width, input bit byte_mode);
        return byte_mode ? (width + 7) / 8 : width;
    endfunction

endpackage

// File: rtl/rf_wr_gate.sv
// Module: rf_wr_gate
// Decides whether the current write takes effect and expands the write mask
// into one enable per data bit. Assumes reset outranks retention, which
// outranks the write request.
module rf_wr_gate #(
    parameter int WORDS     = 12,
    parameter int WIDTH     = 16,
    parameter int AW        = 4,
    parameter int MASK_W    = 16,
    parameter bit BYTE_MODE = 1'b0
) (
    input  logic              rst_n,
    input  logic              ret_hold,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [MASK_W-1:0] wr_mask,
    output logic              wr_go,
    output logic [WIDTH-1:0]  bit_en
);

    localparam logic [AW:0] WORD_LIMIT = (AW + 1)'(WORDS);

    // Effective write: not in reset, not in retention, address in range.
    always_comb begin
        wr_go = wr_en && rst_n && !ret_hold && ({1'b0, wr_addr} < WORD_LIMIT);
    end

    // Mask expansion: the granularity parameter picks the mapping.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (BYTE_MODE) begin : g_byte
            assign bit_en[i] = wr_mask[i / 8];
        end else begin : g_single
            assign bit_en[i] = wr_mask[i];
        end
    end

endmodule

// File: rtl/rf_array.sv
// Module: rf_array
// Storage words with a synchronous active-low clear and a bit-masked write.
// Assumes wr_go already accounts for retention, range and reset priority.
module rf_array #(
    parameter int WORDS = 12,
    parameter int WIDTH = 16,
    parameter int AW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_go,
    input  logic [AW-1:0]          wr_addr,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [WIDTH-1:0]       bit_en,
    output logic [WORDS*WIDTH-1:0] mem_flat
);

    logic [WIDTH-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // One word: clear on reset, merge enabled bits on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (wr_go && (wr_addr == AW'(w))) begin
                mem[w] <= (mem[w] & ~bit_en) | (wr_data & bit_en);
            end
        end
        assign mem_flat[w*WIDTH +: WIDTH] = mem[w];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_flat == '0)); // R1

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(mem_flat)); // R2

endmodule

// File: rtl/rf_rd_port.sv
// Module: rf_rd_port
// One combinational read port: word select, out-of-range zeroing, and the
// optional same-cycle bypass of the masked write data.
// Assumes mem_flat holds word w at slice w*WIDTH.
module rf_rd_port #(
    parameter int WORDS      = 12,
    parameter int WIDTH      = 16,
    parameter int AW         = 4,
    parameter bit WRITE_THRU = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          rd_addr,
    input  logic [WORDS*WIDTH-1:0] mem_flat,
    input  logic                   wr_go,
    input  logic [AW-1:0]          wr_addr,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [WIDTH-1:0]       bit_en,
    output logic [WIDTH-1:0]       rd_data
);

    localparam logic [AW:0] WORD_LIMIT = (AW + 1)'(WORDS);

    logic [WIDTH-1:0] stored;

    // Word select; addresses with no word leave zero.
    always_comb begin
        stored = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rd_addr == AW'(w)) stored = mem_flat[w*WIDTH +: WIDTH];
        end
    end

    if (WRITE_THRU) begin : g_bypass
        // Bypass: enabled bits come from the write data on an address match.
        always_comb begin
            if (wr_go && (rd_addr == wr_addr)) rd_data = (stored & ~bit_en) | (wr_data & bit_en);
            else rd_data = stored;
        end

        AST_BYPASS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && (rd_addr == wr_addr)) |-> ((rd_data & bit_en) == (wr_data & bit_en))); // R5
    end else begin : g_plain
        assign rd_data = stored;
    end

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr} >= WORD_LIMIT) |-> (rd_data == '0)); // R8

endmodule

// File: rtl/mrp_regfile.sv
// Module: mrp_regfile
// Register file with one masked synchronous write port and RD_PORTS
// combinational read ports (1, 2 or 4), optional write-through, synchronous
// active-low clear and a retention hold. Assumes WORDS in 2..128, WIDTH in 4..144.
module mrp_regfile
    import mrp_rf_pkg::*;
#(
    parameter int  WORDS      = 12,
    parameter int  WIDTH      = 16,
    parameter int  RD_PORTS   = 2,
    parameter bit  WRITE_THRU = 1'b1,
    parameter bit  BYTE_MODE  = 1'b0,
    localparam int AW         = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int MASK_W     = mask_width(WIDTH, BYTE_MODE)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ret_hold,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [WIDTH-1:0]          wr_data,
    input  logic [MASK_W-1:0]         wr_mask,
    input  logic [RD_PORTS*AW-1:0]    rd_addr,
    output logic [RD_PORTS*WIDTH-1:0] rd_data
);

    localparam logic [AW:0] WORD_LIMIT = (AW + 1)'(WORDS);

    logic                   wr_go;
    logic [WIDTH-1:0]       bit_en;
    logic [WORDS*WIDTH-1:0] mem_flat;

    rf_wr_gate #(
        .WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .MASK_W(MASK_W), .BYTE_MODE(BYTE_MODE)
    ) u_gate (
        .rst_n(rst_n), .ret_hold(ret_hold), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mask(wr_mask), .wr_go(wr_go), .bit_en(bit_en)
    );

    rf_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr),
        .wr_data(wr_data), .bit_en(bit_en), .mem_flat(mem_flat)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        rf_rd_port #(
            .WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .WRITE_THRU(WRITE_THRU)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr[p*AW +: AW]),
            .mem_flat(mem_flat), .wr_go(wr_go), .wr_addr(wr_addr),
            .wr_data(wr_data), .bit_en(bit_en), .rd_data(rd_data[p*WIDTH +: WIDTH])
        );
    end

    AST_RETENTION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hold |=> $stable(mem_flat)); // R6

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wr_addr} >= WORD_LIMIT) |=> $stable(mem_flat)); // R8

endmodule

// File: tb/mrp_regfile_bench.sv
// Bench: two configurations driven by shared stimulus and compared every cycle
// against a behavioural model of the requirements.
module mrp_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 12;
    localparam int WIDTH = 16;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, ret_hold = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0, mask_a = '0;
    logic [1:0] mask_b = '0;
    logic [AW-1:0] ra [4];
    logic [2*WIDTH-1:0] rd_a;
    logic [4*WIDTH-1:0] rd_b;
    logic [WIDTH-1:0] mdl_a [WORDS];
    logic [WIDTH-1:0] mdl_b [WORDS];
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Configuration A: 2 ports, bit mask, write-through on.
    mrp_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .RD_PORTS(2), .WRITE_THRU(1'b1), .BYTE_MODE(1'b0))
    u_mrp_regfile (
        .clk(clk), .rst_n(rst_n), .ret_hold(ret_hold), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(mask_a), .rd_addr({ra[1], ra[0]}), .rd_data(rd_a)
    );

    // Configuration B: 4 ports, byte mask, write-through off.
    mrp_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .RD_PORTS(4), .WRITE_THRU(1'b0), .BYTE_MODE(1'b1))
    u_mrp_regfile_b (
        .clk(clk), .rst_n(rst_n), .ret_hold(ret_hold), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(mask_b), .rd_addr({ra[3], ra[2], ra[1], ra[0]}), .rd_data(rd_b)
    );

    function automatic logic [WIDTH-1:0] bmask();
        return {{8{mask_b[1]}}, {8{mask_b[0]}}};
    endfunction

    function automatic bit write_live();
        return rst_n && wr_en && !ret_hold && (wr_addr < WORDS);
    endfunction

    function automatic logic [WIDTH-1:0] exp_a(input int p);
        logic [WIDTH-1:0] v;
        if (ra[p] >= WORDS) return '0;
        v = mdl_a[ra[p]];
        if (write_live() && ra[p] == wr_addr) v = (v & ~mask_a) | (wr_data & mask_a);
        return v;
    endfunction

    function automatic logic [WIDTH-1:0] exp_b(input int p);
        if (ra[p] >= WORDS) return '0;
        return mdl_b[ra[p]];
    endfunction

    task automatic chk(input string tag, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
        end
    endtask

    // One cycle: compare combinational reads, then update the model at the edge.
    task automatic step(input string tag);
        #1;
        for (int p = 0; p < 2; p++) chk({tag, " cfgA"}, rd_a[p*WIDTH +: WIDTH], exp_a(p));
        for (int p = 0; p < 4; p++) chk({tag, " cfgB"}, rd_b[p*WIDTH +: WIDTH], exp_b(p));
        @(posedge clk);
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mdl_a[w] = '0;
                mdl_b[w] = '0;
            end
        end else if (write_live()) begin
            mdl_a[wr_addr] = (mdl_a[wr_addr] & ~mask_a) | (wr_data & mask_a);
            mdl_b[wr_addr] = (mdl_b[wr_addr] & ~bmask()) | (wr_data & bmask());
        end
        @(negedge clk);
    endtask

    task automatic set_reads(input int a0, input int a1, input int a2, input int a3);
        ra[0] = AW'(a0); ra[1] = AW'(a1); ra[2] = AW'(a2); ra[3] = AW'(a3);
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] ma, input logic [1:0] mb);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; mask_a = ma; mask_b = mb;
    endtask

    initial begin
        set_reads(0, 0, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int w = 0; w < WORDS; w++) begin mdl_a[w] = '0; mdl_b[w] = '0; end

        // R1: after reset, every read port returns zero.
        set_reads(0, 5, 11, 7);
        step("R1");
        rst_n = 1'b1;
        set_reads(1, 2, 3, 4);
        step("R1");

        // R2/R5: full write to word 3, bypass visible on A only.
        do_write(3, 16'hA5C3, 16'hFFFF, 2'b11);
        set_reads(3, 4, 3, 3);
        step("R5");
        wr_en = 1'b0;
        step("R2");

        // R4/R5: masked writes, bit mask on A and upper byte on B.
        do_write(3, 16'hFFFF, 16'h00F0, 2'b10);
        step("R5");
        wr_en = 1'b0;
        step("R4");
        do_write(3, 16'h0000, 16'h8001, 2'b01);
        step("R5");
        wr_en = 1'b0;
        step("R4");

        // R6: retention drops the write and the bypass.
        ret_hold = 1'b1;
        do_write(3, 16'h1111, 16'hFFFF, 2'b11);
        step("R6");
        wr_en = 1'b0;
        step("R6");
        ret_hold = 1'b0;

        // R8: out-of-range write and read.
        do_write(13, 16'h1234, 16'hFFFF, 2'b11);
        set_reads(13, 5, 15, 12);
        step("R8");
        wr_en = 1'b0;
        for (int w = 0; w < WORDS; w += 4) begin
            set_reads(w, w + 1, w + 2, w + 3);
            step("R8");
        end

        // R3: distinct data per word, four ports at different addresses.
        for (int w = 0; w < WORDS; w++) begin
            do_write(w, WIDTH'(16'h1357 * (w + 1)), 16'hFFFF, 2'b11);
            set_reads(w, (w + 5) % 16, 11 - w, (w + 3) % 12);
            step("R3");
        end
        wr_en = 1'b0;
        set_reads(2, 9, 0, 14);
        step("R3");

        // R7: reset wins over retention and write.
        rst_n = 1'b0; ret_hold = 1'b1;
        do_write(3, 16'hBEEF, 16'hFFFF, 2'b11);
        set_reads(3, 0, 11, 6);
        step("R7");
        rst_n = 1'b1; ret_hold = 1'b0; wr_en = 1'b0;
        step("R7");

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            rst_n    = ($urandom % 100) != 0;
            ret_hold = ($urandom % 8) == 0;
            wr_en    = ($urandom % 2) == 1;
            wr_addr  = AW'($urandom % 16);
            wr_data  = WIDTH'($urandom);
            mask_a   = WIDTH'($urandom);
            mask_b   = 2'($urandom);
            for (int p = 0; p < 4; p++) ra[p] = (($urandom % 3) == 0) ? wr_addr : AW'($urandom % 16);
            step("R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule